// File: doc/BRIEF.md
# Configurable Pad Function Selector

This block holds the control logic for one configurable I/O pad. A 32-bit configuration register sits behind a simple write/read port. The register picks which of eight internal peripheral signals drives the pad. It also picks where the pull resistors take their request from, holds a drive-strength code, and holds a fixed output value and output enable for low-power operation. Every peripheral sees the pad input level directly.

Edge detection is done in this cell, not in a GPIO controller. The pad input passes through a synchronizer. A rising or falling transition, if enabled, sets a sticky status flag. An external per-peripheral wakeup enable gates that flag into a wakeup request. A clear control drops the flag and holds detection off while it is set.

Top module: `pinmux_cell`

## Requirements
- R1: After reset the register reads 0x0000_0800: every field is zero except the drive code in bits 12:10, which is 3'b010.
- R2: Bit 3 and bits 31:16 always read as zero, and writing ones to them changes nothing. Every other bit reads back what was last written.
- R3: In run mode, the function number held in bits 2:0 chooses which peripheral's output and output enable reach pad_out_o and pad_oe_o.
- R4: When lp_mode_i is high and bit 9 is set, pad_out_o equals bit 8 and pad_oe_o equals the inverse of bit 7. If either condition is false, the selected function drives the pad.
- R5: When bit 15 is 1, bit 14 requests the pull-up and bit 13 requests the pull-down.
- R6: When bit 15 is 0, the selected function's 2-bit request drives the pulls. In that request, bit [1] asks for pull-up and bit [0] asks for pull-down.
- R7: pull_up_o and pull_dn_o are never high together. If both are requested, the pull-down is dropped.
- R8: drive_o always equals register bits 12:10.
- R9: The pad input level appears unchanged and without delay on every bit of fn_in_o.
- R10: With bit 4 set, a rising pad transition sets a sticky edge flag. With bit 5 set, a falling transition sets it. The flag rises within four clocks of the pad change, because the input passes two synchronizer flops. Transitions whose enable bit is clear leave the flag low.
- R11: While bit 6 is 1, the edge flag is held clear and no transition sets it. This clear wins over an edge seen in the same cycle.
- R12: wake_req_o is high exactly when the edge flag is set and wake_en_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data |
| fn_out_i | input | 8 | Output value from each peripheral function |
| fn_oe_i | input | 8 | Output enable from each peripheral function |
| fn_pull_i | input | 16 | Pull request per function, 2 bits each ([1] up, [0] down) |
| fn_in_o | output | 8 | Pad input level, one copy per function |
| pad_in_i | input | 1 | Level seen on the pad |
| lp_mode_i | input | 1 | Chip is in a low-power state |
| wake_en_i | input | 1 | Wakeup enable for the peripheral owning this pin |
| pad_out_o | output | 1 | Pad output data |
| pad_oe_o | output | 1 | Pad output enable |
| pull_up_o | output | 1 | Pull-up enable |
| pull_dn_o | output | 1 | Pull-down enable |
| drive_o | output | 3 | Drive strength and slew code |
| wake_req_o | output | 1 | Wakeup request |

## Verification
Random register words combined with random peripheral outputs, enables, pull requests and the low-power flag cover the routing. These separate a wrong function index from a missing override and a wrong pull source. Both pulls asked for at once shows whether the pull-down is dropped. Directed pad transitions are applied with only the rising enable, only the falling enable, and the clear bit held. These show whether each edge enable acts alone, whether the flag stays set, and whether clear blocks detection. Toggling the wakeup enable around a set flag isolates the gating.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
   localparam int CFG_W      = 32;
   localparam int FSEL_LSB   = 0;
   localparam int FSEL_W     = 3;
   localparam int RISE_BIT   = 4;
   localparam int FALL_BIT   = 5;
   localparam int ECLR_BIT   = 6;
   localparam int LPOEN_BIT  = 7;
   localparam int LPDAT_BIT  = 8;
   localparam int LPSEL_BIT  = 9;
   localparam int DRV_LSB    = 10;
   localparam int DRV_W      = 3;
   localparam int PD_BIT     = 13;
   localparam int PU_BIT     = 14;
   localparam int PSRC_BIT   = 15;
   localparam logic [CFG_W-1:0] CFG_WMASK = 32'h0000_FFF7;
   localparam logic [CFG_W-1:0] CFG_RST   = 32'h0000_0800;

   typedef struct packed {
      logic up;
      logic dn;
   } pull_t;
endpackage

// File: rtl/pinmux_cfg_reg.sv
module pinmux_cfg_reg
   import pinmux_pkg::*;
#(
   parameter logic [CFG_W-1:0] WMASK = CFG_WMASK,
   parameter logic [CFG_W-1:0] RSTV  = CFG_RST
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [CFG_W-1:0] wdata_i,
   output logic [CFG_W-1:0] cfg_o
);
   initial begin
      if ((RSTV & ~WMASK) != '0)
         $error("reset value sets bits outside the writable mask");
   end

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= RSTV;
      else if (we_i)  cfg_q <= wdata_i & WMASK;
   end

   assign cfg_o = cfg_q;

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q & ~WMASK) == '0);
   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> cfg_q == ($past(wdata_i) & WMASK));
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route
   import pinmux_pkg::*;
#(
   parameter int NUM_FUNC = 8,
   localparam int SEL_W = FSEL_W
) (
   input  logic [SEL_W-1:0]    sel_i,
   input  logic [NUM_FUNC-1:0] fn_out_i,
   input  logic [NUM_FUNC-1:0] fn_oe_i,
   input  pull_t [NUM_FUNC-1:0] fn_pull_i,
   input  logic                lp_mode_i,
   input  logic                lp_sel_i,
   input  logic                lp_dat_i,
   input  logic                lp_oe_n_i,
   input  logic                pull_src_i,
   input  logic                reg_pu_i,
   input  logic                reg_pd_i,
   output logic                pad_out_o,
   output logic                pad_oe_o,
   output logic                pull_up_o,
   output logic                pull_dn_o
);
   initial begin
      if (NUM_FUNC < 2 || NUM_FUNC > (1 << SEL_W))
         $error("NUM_FUNC must lie between 2 and the field range");
   end

   logic  run_out, run_oe;
   pull_t run_pull, req;

   generate
      if (NUM_FUNC == (1 << SEL_W)) begin : g_full
         always_comb begin
            run_out  = fn_out_i[sel_i];
            run_oe   = fn_oe_i[sel_i];
            run_pull = fn_pull_i[sel_i];
         end
      end else begin : g_part
         always_comb begin
            run_out  = 1'b0;
            run_oe   = 1'b0;
            run_pull = '0;
            for (int k = 0; k < NUM_FUNC; k++) begin
               if (sel_i == SEL_W'(k)) begin
                  run_out  = fn_out_i[k];
                  run_oe   = fn_oe_i[k];
                  run_pull = fn_pull_i[k];
               end
            end
         end
      end
   endgenerate

   always_comb begin
      if (lp_mode_i && lp_sel_i) begin
         pad_out_o = lp_dat_i;
         pad_oe_o  = ~lp_oe_n_i;
      end else begin
         pad_out_o = run_out;
         pad_oe_o  = run_oe;
      end
      req.up = pull_src_i ? reg_pu_i : run_pull.up;
      req.dn = pull_src_i ? reg_pd_i : run_pull.dn;
      pull_up_o = req.up;
      pull_dn_o = req.dn & ~req.up;
   end

   // R7
   pull_excl_chk: assert final (!(pull_up_o && pull_dn_o));
endmodule

// File: rtl/pinmux_edge.sv
module pinmux_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pad_i,
   input  logic rise_en_i,
   input  logic fall_en_i,
   input  logic clr_i,
   input  logic wake_en_i,
   output logic wake_req_o
);
   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic prev_q, flag_q, hit;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= (s == 0) ? pad_i : sync_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign hit = (rise_en_i &  sync_q[SYNC_STAGES-1] & ~prev_q) |
                (fall_en_i & ~sync_q[SYNC_STAGES-1] &  prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (clr_i) flag_q <= 1'b0;
      else if (hit)   flag_q <= 1'b1;
   end

   assign wake_req_o = flag_q & wake_en_i;

   // R11
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !flag_q);
   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);
   // R10
   flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(rise_en_i || fall_en_i));
endmodule

// File: rtl/pinmux_cell.sv
module pinmux_cell
   import pinmux_pkg::*;
#(
   parameter int NUM_FUNC    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we_i,
   input  logic [31:0]           cfg_wdata_i,
   output logic [31:0]           cfg_rdata_o,
   input  logic [NUM_FUNC-1:0]   fn_out_i,
   input  logic [NUM_FUNC-1:0]   fn_oe_i,
   input  logic [2*NUM_FUNC-1:0] fn_pull_i,
   output logic [NUM_FUNC-1:0]   fn_in_o,
   input  logic                  pad_in_i,
   input  logic                  lp_mode_i,
   input  logic                  wake_en_i,
   output logic                  pad_out_o,
   output logic                  pad_oe_o,
   output logic                  pull_up_o,
   output logic                  pull_dn_o,
   output logic [2:0]            drive_o,
   output logic                  wake_req_o
);
   logic [CFG_W-1:0] cfg;
   pull_t [NUM_FUNC-1:0] pulls;

   pinmux_cfg_reg u_reg (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .cfg_o(cfg)
   );

   generate
      for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
         assign pulls[f].up = fn_pull_i[2*f+1];
         assign pulls[f].dn = fn_pull_i[2*f];
         assign fn_in_o[f]  = pad_in_i;
      end
   endgenerate

   pinmux_route #(.NUM_FUNC(NUM_FUNC)) u_route (
      .sel_i(cfg[FSEL_LSB +: FSEL_W]),
      .fn_out_i(fn_out_i), .fn_oe_i(fn_oe_i), .fn_pull_i(pulls),
      .lp_mode_i(lp_mode_i), .lp_sel_i(cfg[LPSEL_BIT]),
      .lp_dat_i(cfg[LPDAT_BIT]), .lp_oe_n_i(cfg[LPOEN_BIT]),
      .pull_src_i(cfg[PSRC_BIT]), .reg_pu_i(cfg[PU_BIT]), .reg_pd_i(cfg[PD_BIT]),
      .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
      .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o)
   );

   pinmux_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pad_i(pad_in_i),
      .rise_en_i(cfg[RISE_BIT]), .fall_en_i(cfg[FALL_BIT]), .clr_i(cfg[ECLR_BIT]),
      .wake_en_i(wake_en_i), .wake_req_o(wake_req_o)
   );

   assign cfg_rdata_o = cfg;
   assign drive_o     = cfg[DRV_LSB +: DRV_W];

   // R4
   lp_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode_i && cfg_rdata_o[LPSEL_BIT]) |->
         (pad_oe_o == !cfg_rdata_o[LPOEN_BIT] && pad_out_o == cfg_rdata_o[LPDAT_BIT]));
   // R12
   wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req_o |-> wake_en_i);
   // R8
   drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_we_i) |-> drive_o == ($past(cfg_wdata_i[DRV_LSB +: DRV_W])));
endmodule

// File: tb/test_pinmux_cell.sv
module test_pinmux_cell;
   localparam time CLK_P = 5ns;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [7:0] fn_out = '0, fn_oe = '0, fn_in;
   logic [15:0] fn_pull = '0;
   logic pad_in = 1'b0, lp_mode = 1'b0, wake_en = 1'b0;
   logic pad_out, pad_oe, pull_up, pull_dn, wake_req;
   logic [2:0] drive;
   int compared = 0, mismatched = 0;

   always #(CLK_P/2) clk = ~clk;

   pinmux_cell i_pinmux_cell (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata), .fn_out_i(fn_out), .fn_oe_i(fn_oe),
      .fn_pull_i(fn_pull), .fn_in_o(fn_in), .pad_in_i(pad_in),
      .lp_mode_i(lp_mode), .wake_en_i(wake_en), .pad_out_o(pad_out),
      .pad_oe_o(pad_oe), .pull_up_o(pull_up), .pull_dn_o(pull_dn),
      .drive_o(drive), .wake_req_o(wake_req)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [1:0] exp_pull(logic [31:0] c, logic [15:0] p);
      logic u, d;
      u = c[15] ? c[14] : p[2*c[2:0]+1];
      d = c[15] ? c[13] : p[2*c[2:0]];
      return {u, d & ~u};
   endfunction

   function automatic logic [1:0] exp_pad(logic [31:0] c, logic lp, logic [7:0] o, logic [7:0] e);
      if (lp && c[9]) return {c[8], ~c[7]};
      return {o[c[2:0]], e[c[2:0]]};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      check("R1 reset value", cfg_rdata, 32'h0000_0800);
      check("R8 reset drive", {29'd0, drive}, 32'd2);
      check("R12 no wake at reset", {31'd0, wake_req}, 32'd0);

      // R2 reserved bits
      wr(32'hFFFF_FFFF);
      check("R2 reserved masked", cfg_rdata, 32'h0000_FFF7);
      wr(32'h0000_0000);

      // R10 rising only
      wake_en = 1'b1;
      wr(32'h0000_0010);
      wait_cyc(4);
      check("R10 idle no flag", {31'd0, wake_req}, 32'd0);
      pad_in = 1'b1; wait_cyc(4);
      check("R10 rise sets flag", {31'd0, wake_req}, 32'd1);
      pad_in = 1'b0; wait_cyc(4);
      check("R10 flag sticky", {31'd0, wake_req}, 32'd1);
      // R11 clear held
      wr(32'h0000_0050);
      wait_cyc(1);
      check("R11 clear drops flag", {31'd0, wake_req}, 32'd0);
      pad_in = 1'b1; wait_cyc(4);
      check("R11 clear blocks edge", {31'd0, wake_req}, 32'd0);
      // R10 falling enable only, rising ignored
      wr(32'h0000_0020);
      pad_in = 1'b0; wait_cyc(4);
      check("R10 fall sets flag", {31'd0, wake_req}, 32'd1);
      wr(32'h0000_0040); wr(32'h0000_0020);
      pad_in = 1'b1; wait_cyc(4);
      check("R10 rise ignored with only fall enabled", {31'd0, wake_req}, 32'd0);
      // R12 gating
      wr(32'h0000_0010);
      wake_en = 1'b0;
      pad_in = 1'b0; wait_cyc(4);
      pad_in = 1'b1; wait_cyc(4);
      check("R12 gated off", {31'd0, wake_req}, 32'd0);
      wake_en = 1'b1; #1;
      check("R12 gate on", {31'd0, wake_req}, 32'd1);

      // R7 directed: both pulls from register
      wr(32'h0000_E000);
      check("R7 both requested", {30'd0, pull_up, pull_dn}, 32'd2);

      // R3-R9 random
      for (int i = 0; i < 400; i++) begin
         logic [31:0] c;
         logic [1:0] pp, pd;
         c = $urandom();
         fn_out = 8'($urandom()); fn_oe = 8'($urandom());
         fn_pull = 16'($urandom()); lp_mode = 1'($urandom());
         pad_in = 1'($urandom());
         wr(c);
         c = c & 32'h0000_FFF7;
         pd = exp_pad(c, lp_mode, fn_out, fn_oe);
         pp = exp_pull(c, fn_pull);
         check("R2 readback", cfg_rdata, c);
         if (lp_mode && c[9]) check("R4 low-power pad", {30'd0, pad_out, pad_oe}, {30'd0, pd});
         else                 check("R3 function pad", {30'd0, pad_out, pad_oe}, {30'd0, pd});
         if (c[15]) check("R5 register pulls", {30'd0, pull_up, pull_dn}, {30'd0, pp});
         else       check("R6 function pulls", {30'd0, pull_up, pull_dn}, {30'd0, pp});
         check("R7 pulls exclusive", {31'd0, pull_up & pull_dn}, 32'd0);
         check("R8 drive code", {29'd0, drive}, {29'd0, c[12:10]});
         check("R9 fan-out", {24'd0, fn_in}, {24'd0, {8{pad_in}}});
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule